// File: doc/BRIEF.md
# Character LCD host port

This block is the processor-facing port of a character display controller. A host drives a register-select line, a read/write line and an enable strobe, and exchanges bytes over an 8-line data bus. Each completed strobe is decoded into one of four accesses: instruction write, status read, data write or data read. Decoded writes go to an instruction executor as a one-cycle pulse. Reads are served from the port itself. A status read returns the executor's busy flag together with its address counter. A data read returns a prefetch register that the executor refills whenever it sets an address or steps past a read.

The bus can run at full byte width or on its upper four lines only. In the narrow mode every byte takes two strobes, and the port pairs them up. A function-set instruction that arrives through the port chooses the width, and the port tracks that width itself. The strobe is asynchronous to the system clock and passes through a synchronizer. A transfer takes effect when the strobe falls.

Top module: `lcd_host_port`

## Requirements
- R1: The access is given by {select, read}: 00 is an instruction write, 01 a status read, 10 a data write and 11 a data read. An accepted write produces `ex_valid` with `ex_sel` equal to the select bit and `ex_byte` equal to the assembled byte.
- R2: In 8-bit mode, a status read drives the busy input on line 7 and the 7-bit address counter input on lines 6..0.
- R3: A data read drives the prefetch register on the bus. When an accepted data read completes, `rd_ack` pulses for one cycle.
- R4: The prefetch register loads `pf_data` in every cycle where `pf_valid` is high, and it holds its value in all other cycles.
- R5: After reset the bus is 8-bit, the next transfer counts as a first nibble, the prefetch register reads 0, and `ex_valid` and `rd_ack` are low.
- R6: An accepted instruction write whose bits 7..5 are 001 is a function set. Its bit 4 selects the width: 1 gives 8-bit and 0 gives 4-bit.
- R7: In 4-bit mode only lines 7..4 carry data. A byte is two transfers, high nibble first, and the write pulse follows only the second transfer. Lines 3..0 are ignored.
- R8: In 4-bit mode, status and data reads present the upper nibble of the source on lines 7..4 in the first transfer and the lower nibble in the second.
- R9: Lines 7..4 are output-enabled exactly while read=1 and enable=1. Lines 3..0 are output-enabled only under the same condition and only in 8-bit mode.
- R10: When the busy input is high at completion, a write produces no `ex_valid`, a data read produces no `rd_ack`, and a function set does not change the width. Nibble pairing still advances, and status reads still work.
- R11: After a width change, the next transfer is treated as a high (first) nibble.
- R12: A transfer commits on the falling edge of enable. `ex_valid` (or `rd_ack`) is high for exactly one cycle, on the third rising clock edge after the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_sel | input | 1 | Register select from host |
| hb_rd | input | 1 | 1 = read, 0 = write |
| hb_en | input | 1 | Asynchronous transfer strobe |
| hb_din | input | 8 | Data bus value seen at the pads |
| hb_dout | output | 8 | Data bus value driven on reads |
| hb_doe | output | 8 | Per-line output enable for the bus pads |
| ex_busy | input | 1 | Busy flag from the executor |
| ex_ac | input | 7 | Address counter from the executor |
| ex_valid | output | 1 | One-cycle pulse for a decoded write |
| ex_sel | output | 1 | Select bit of the decoded write |
| ex_byte | output | 8 | Byte of the decoded write |
| rd_ack | output | 1 | One-cycle pulse when a data read is consumed |
| pf_valid | input | 1 | Load strobe for the prefetch register |
| pf_data | input | 8 | Next RAM byte from the executor |

## Verification
Every cycle, the assertions check four things: the commit and write pulses last one cycle, pulses never follow a busy completion, the width only changes after a commit, and the low lines stay undriven in narrow mode. They also check that the prefetch register holds without a load strobe and that the nibble phase stays clear at full width. Other behaviour only shows up in the bench scenarios. That covers nibble order and byte assembly, the values read back at each phase, the exact cycle of each pulse, and a width switch made through a real function-set byte. It also covers rejected instructions leaving the width unchanged, and alignment surviving a nibble pair sent while busy.

// File: rtl/lcd_hp_pkg.sv
`timescale 1ns/1ps
package lcd_hp_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int AC_W   = BYTE_W - 1;
  localparam logic [2:0] FSET_TAG = 3'b001;
  localparam int FSET_WIDTH_BIT = 4;

  // encoding is {select, read}
  typedef enum logic [1:0] {
    ACC_INSTR_WR  = 2'b00,
    ACC_STATUS_RD = 2'b01,
    ACC_DATA_WR   = 2'b10,
    ACC_DATA_RD   = 2'b11
  } acc_e;

  function automatic logic is_fset(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: 3] == FSET_TAG;
  endfunction
endpackage

// File: rtl/lcd_hp_strobe_sync.sv
`timescale 1ns/1ps
module lcd_hp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pin,
  output logic commit
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;
  logic [LAST:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LAST-1:0], en_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // falling edge of the synchronised strobe
  assign commit = sh_q[LAST] & ~sh_q[LAST-1];

  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R12
endmodule

// File: rtl/lcd_hp_nibble.sv
`timescale 1ns/1ps
module lcd_hp_nibble
  import lcd_hp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  acc_e              acc,
  input  logic [BYTE_W-1:0] din,
  input  logic              busy,
  output logic              wide,
  output logic              phase,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  logic             wide_q, wide_d;
  logic             phase_q, phase_d;
  logic [NIB_W-1:0] hi_q, hi_d;
  logic             fset_hit;
  logic             width_chg;

  assign byte_done = commit & (wide_q | phase_q);
  assign byte_val  = wide_q ? din : {hi_q, din[BYTE_W-1 -: NIB_W]};
  assign fset_hit  = byte_done & ~busy & (acc == ACC_INSTR_WR) & is_fset(byte_val);
  assign width_chg = fset_hit & (byte_val[FSET_WIDTH_BIT] != wide_q);

  always_comb begin
    wide_d  = wide_q;
    phase_d = phase_q;
    hi_d    = hi_q;
    if (!wide_q) begin
      phase_d = ~phase_q;
      if (!phase_q) hi_d = din[BYTE_W-1 -: NIB_W];
    end
    if (fset_hit)  wide_d  = byte_val[FSET_WIDTH_BIT];
    if (width_chg) phase_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q  <= 1'b1;
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else if (commit) begin
      wide_q  <= wide_d;
      phase_q <= phase_d;
      hi_q    <= hi_d;
    end
  end

  assign wide  = wide_q;
  assign phase = phase_q;

  AST_PHASE_IDLE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    wide_q |-> !phase_q); // R7
  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wide_q && !width_chg) |=> (phase_q != $past(phase_q))); // R7
  AST_WIDTH_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wide_q) |-> ($past(commit) && !$past(busy))); // R10
  AST_WIDTH_CHG_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    width_chg |=> !phase_q); // R11
endmodule

// File: rtl/lcd_hp_readmux.sv
`timescale 1ns/1ps
module lcd_hp_readmux
  import lcd_hp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_valid,
  input  logic [BYTE_W-1:0] pf_data,
  input  logic              sel,
  input  logic              busy,
  input  logic [AC_W-1:0]   ac,
  input  logic              wide,
  input  logic              phase,
  output logic [BYTE_W-1:0] dout
);
  logic [BYTE_W-1:0] dreg_q, dreg_d;
  logic [BYTE_W-1:0] src;

  always_comb begin
    dreg_d = pf_valid ? pf_data : dreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreg_q <= '0;
    else        dreg_q <= dreg_d;
  end

  always_comb begin
    src = sel ? dreg_q : {busy, ac};
    if (wide)       dout = src;
    else if (phase) dout = {src[NIB_W-1:0], {NIB_W{1'b0}}};
    else            dout = {src[BYTE_W-1 -: NIB_W], {NIB_W{1'b0}}};
  end

  AST_DREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid |=> $stable(dreg_q)); // R4
endmodule

// File: rtl/lcd_host_port.sv
`timescale 1ns/1ps
module lcd_host_port
  import lcd_hp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_sel,
  input  logic              hb_rd,
  input  logic              hb_en,
  input  logic [BYTE_W-1:0] hb_din,
  output logic [BYTE_W-1:0] hb_dout,
  output logic [BYTE_W-1:0] hb_doe,
  input  logic              ex_busy,
  input  logic [AC_W-1:0]   ex_ac,
  output logic              ex_valid,
  output logic              ex_sel,
  output logic [BYTE_W-1:0] ex_byte,
  output logic              rd_ack,
  input  logic              pf_valid,
  input  logic [BYTE_W-1:0] pf_data
);
  acc_e              acc;
  logic              commit;
  logic              wide, phase, byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic              accept, wr_fire, rd_fire, drive_hi;

  logic              exv_q, exv_d, exs_q, exs_d, rdack_q, rdack_d;
  logic [BYTE_W-1:0] exb_q, exb_d;

  assign acc = acc_e'({hb_sel, hb_rd});

  lcd_hp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_pin (hb_en),
    .commit (commit)
  );

  lcd_hp_nibble u_nib (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .acc       (acc),
    .din       (hb_din),
    .busy      (ex_busy),
    .wide      (wide),
    .phase     (phase),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  lcd_hp_readmux u_rmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .pf_valid (pf_valid),
    .pf_data  (pf_data),
    .sel      (hb_sel),
    .busy     (ex_busy),
    .ac       (ex_ac),
    .wide     (wide),
    .phase    (phase),
    .dout     (hb_dout)
  );

  assign accept  = byte_done & ~ex_busy;
  assign wr_fire = accept & ((acc == ACC_INSTR_WR) | (acc == ACC_DATA_WR));
  assign rd_fire = accept & (acc == ACC_DATA_RD);

  always_comb begin
    exv_d   = wr_fire;
    exs_d   = wr_fire ? hb_sel : exs_q;
    exb_d   = wr_fire ? byte_val : exb_q;
    rdack_d = rd_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exv_q   <= 1'b0;
      exs_q   <= 1'b0;
      exb_q   <= '0;
      rdack_q <= 1'b0;
    end else begin
      exv_q   <= exv_d;
      exs_q   <= exs_d;
      exb_q   <= exb_d;
      rdack_q <= rdack_d;
    end
  end

  assign ex_valid = exv_q;
  assign ex_sel   = exs_q;
  assign ex_byte  = exb_q;
  assign rd_ack   = rdack_q;

  assign drive_hi = hb_rd & hb_en;
  assign hb_doe   = {{NIB_W{drive_hi}}, {NIB_W{drive_hi & wide}}};

  AST_LOW_LINES_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (hb_doe[NIB_W-1:0] == '0)); // R9
  AST_EXV_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> !$past(ex_busy)); // R10
  AST_RDACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> !$past(ex_busy)); // R10
  AST_EXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |=> !ex_valid); // R12
  AST_RDACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack); // R3
endmodule

// File: tb/lcd_host_port_bench.sv
`timescale 1ns/1ps
module lcd_host_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hb_sel, hb_rd, hb_en;
  logic [7:0] hb_din, hb_dout, hb_doe;
  logic       ex_busy;
  logic [6:0] ex_ac;
  logic       ex_valid, ex_sel, rd_ack, pf_valid;
  logic [7:0] ex_byte, pf_data;

  always #2.5 clk = ~clk;

  lcd_host_port u_lcd_host_port (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_rd(hb_rd), .hb_en(hb_en),
    .hb_din(hb_din), .hb_dout(hb_dout), .hb_doe(hb_doe), .ex_busy(ex_busy),
    .ex_ac(ex_ac), .ex_valid(ex_valid), .ex_sel(ex_sel), .ex_byte(ex_byte),
    .rd_ack(rd_ack), .pf_valid(pf_valid), .pf_data(pf_data)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  bit       r_wide = 1'b1;
  bit       r_phase = 1'b0;
  bit [3:0] r_hi = 4'h0;
  bit [7:0] r_dreg = 8'h00;
  int       due_w = -1;
  int       due_r = -1;
  bit       w_sel;
  bit [7:0] w_byte;
  bit       ev_w, ev_r;
  logic [7:0] exp_oe;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      ev_w = 1'b0;
      ev_r = 1'b0;
      if (due_w > 0) due_w--;
      if (due_w == 0) begin ev_w = 1'b1; due_w = -1; end
      if (due_r > 0) due_r--;
      if (due_r == 0) begin ev_r = 1'b1; due_r = -1; end
      chk(ex_valid == ev_w, "R12", "ex_valid timing", ex_valid, ev_w);
      if (ev_w) begin
        chk(ex_sel == w_sel, "R1", "ex_sel", ex_sel, w_sel);
        chk(ex_byte == w_byte, "R1", "ex_byte", ex_byte, w_byte);
      end
      chk(rd_ack == ev_r, "R3", "rd_ack timing", rd_ack, ev_r);
      exp_oe = {{4{hb_rd & hb_en}}, {4{hb_rd & hb_en & r_wide}}};
      chk(hb_doe == exp_oe, "R9", "output enable", hb_doe, exp_oe);
    end
  end

  task automatic xfer(input bit sel, input bit rd, input logic [7:0] d,
                      input string req);
    bit [7:0] src, expv, mask, byt;
    bit done, ok_acc, nw;
    @(negedge clk);
    hb_sel = sel; hb_rd = rd; hb_din = d; hb_en = 1'b1;
    repeat (3) @(negedge clk);
    if (rd) begin
      src  = sel ? r_dreg : {ex_busy, ex_ac};
      expv = r_wide ? src : (r_phase ? {src[3:0], 4'h0} : {src[7:4], 4'h0});
      mask = r_wide ? 8'hFF : 8'hF0;
      chk((hb_dout & mask) == (expv & mask), req, "read bus", hb_dout & mask, expv & mask);
    end
    hb_en = 1'b0;
    done   = r_wide | r_phase;
    byt    = r_wide ? d : {r_hi, d[7:4]};
    ok_acc = done & !ex_busy;
    if (ok_acc && !rd) begin w_sel = sel; w_byte = byt; due_w = 3; end
    if (ok_acc && rd && sel) due_r = 3;
    repeat (4) @(negedge clk);
    nw = r_wide;
    if (ok_acc && !sel && !rd && byt[7:5] == 3'b001) nw = byt[4];
    if (!r_wide) begin
      if (!r_phase) r_hi = d[7:4];
      r_phase = !r_phase;
    end
    if (nw != r_wide) r_phase = 1'b0;
    r_wide = nw;
  endtask

  task automatic wr4(input bit sel, input logic [7:0] b, input logic [3:0] junk,
                     input string req);
    xfer(sel, 1'b0, {b[7:4], junk}, req);
    xfer(sel, 1'b0, {b[3:0], ~junk}, req);
  endtask

  task automatic rd4(input bit sel, input string req);
    xfer(sel, 1'b1, 8'h00, req);
    xfer(sel, 1'b1, 8'h00, req);
  endtask

  task automatic load_pf(input logic [7:0] d);
    @(negedge clk);
    pf_valid = 1'b1; pf_data = d;
    @(negedge clk);
    pf_valid = 1'b0; pf_data = 8'hEE;
    r_dreg = d;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hb_sel = 1'b0; hb_rd = 1'b0; hb_en = 1'b0; hb_din = 8'h00;
    ex_busy = 1'b0; ex_ac = 7'h15; pf_valid = 1'b0; pf_data = 8'h00;
    repeat (5) @(negedge clk);
    chk(ex_valid == 1'b0, "R5", "ex_valid in reset", ex_valid, 0);
    chk(rd_ack == 1'b0, "R5", "rd_ack in reset", rd_ack, 0);
    chk(hb_doe == 8'h00, "R5", "bus idle in reset", hb_doe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 / R2: 8-bit status and zero prefetch after reset
    xfer(1'b0, 1'b1, 8'h00, "R2");
    xfer(1'b1, 1'b1, 8'h00, "R5");
    // R1: instruction and data writes
    xfer(1'b0, 1'b0, 8'h01, "R1");
    xfer(1'b1, 1'b0, 8'hA5, "R1");
    // R4 / R3: prefetch load and reads
    load_pf(8'h5C);
    xfer(1'b1, 1'b1, 8'h00, "R3");
    xfer(1'b1, 1'b1, 8'h00, "R4");
    load_pf(8'h77);
    xfer(1'b1, 1'b1, 8'h00, "R4");
    // R10: busy rejects writes, function set and data read; status still read
    @(negedge clk); ex_busy = 1'b1; ex_ac = 7'h42;
    xfer(1'b0, 1'b0, 8'h02, "R10");
    xfer(1'b0, 1'b0, 8'h20, "R10");
    xfer(1'b1, 1'b1, 8'h00, "R10");
    xfer(1'b0, 1'b1, 8'h00, "R10");
    @(negedge clk); ex_busy = 1'b0;
    xfer(1'b0, 1'b1, 8'h00, "R10");
    // R6: function set with width bit 0 -> 4-bit
    xfer(1'b0, 1'b0, 8'h28, "R6");
    rd4(1'b0, "R6");
    // R7: nibble pairs, low lines ignored
    wr4(1'b1, 8'h4B, 4'hF, "R7");
    wr4(1'b0, 8'h0C, 4'h3, "R7");
    // R8: narrow reads
    load_pf(8'hD3);
    rd4(1'b1, "R8");
    ex_ac = 7'h6A;
    rd4(1'b0, "R8");
    // R10: nibble pair while busy still advances pairing
    @(negedge clk); ex_busy = 1'b1;
    wr4(1'b1, 8'h99, 4'h0, "R10");
    @(negedge clk); ex_busy = 1'b0;
    wr4(1'b1, 8'h36, 4'h5, "R10");
    // R11: back to 8-bit through a nibble pair, then 8-bit and 4-bit again
    wr4(1'b0, 8'h30, 4'h0, "R11");
    xfer(1'b1, 1'b0, 8'h5A, "R11");
    xfer(1'b0, 1'b1, 8'h00, "R11");
    xfer(1'b0, 1'b0, 8'h2C, "R11");
    wr4(1'b1, 8'hE1, 4'h7, "R11");
    rd4(1'b0, "R11");
    // R12: back-to-back writes each give one pulse
    wr4(1'b1, 8'h11, 4'h2, "R12");
    wr4(1'b1, 8'h22, 4'h4, "R12");
    repeat (6) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule